// File: doc/BRIEF.md
# Blocked Transpose Burst Address Generator

This block turns a traversal request over a large two-dimensional sample matrix into a stream of DRAM burst addresses, given as bank, row and column. The matrix is cut into square tiles of 32 lines by 32 samples. Each tile fills exactly one DRAM row of 1024 words. Tiles are numbered in raster order, and consecutive tile numbers fall in different banks so that row openings overlap.

Inside a tile the words are interleaved. Each 8-word burst holds two neighbouring lines, alternating word by word, over four neighbouring sample positions. The same burst shape therefore serves both line-wise traversal and column-wise traversal.

A traversal request carries a start coordinate, a direction and a burst count. Each pulse on the request input then yields the next burst address one cycle later. The generator walks the matrix with increments, wrap tests and bit concatenation alone, with no multiplication.

Top module: `xpose_addr_gen`

## Requirements
- R1: After reset `valid_o` and `done_o` are both 0.
- R2: A `start_i` pulse loads the direction, the coordinate and the count. If `gen_en_i` is high in the same cycle it is dropped, and `valid_o` is 0 in the next cycle.
- R3: While bursts remain, each cycle with `gen_en_i` high gives exactly one address with `valid_o` high in the next cycle. With no bursts remaining, `gen_en_i` produces no `valid_o`.
- R4: For the burst whose first word is at line y and sample x, the address is as follows. The tile is t = (y>>5)·(W/32) + (x>>5). `bank_o` = t mod 8 and `row_o` = t>>3. `col_o` = ((y mod 32)>>1)·64 + (x mod 32)·2 + (y mod 2).
- R5: Line-wise mode (`mode_i`=0) steps the column by 8 for 16 bursts, covering four lines of one tile. It then moves to the next tile along x on the same four lines. After the last tile of the line it takes the next four-line group from tile column 0. After the last group it wraps to line 0.
- R6: Column-wise mode (`mode_i`=1) steps the column by 64 for 16 bursts, covering four sample positions of one tile. It then moves to the next tile along y. After the last tile row it takes the next four-position group from tile row 0. After the last group it wraps to sample 0.
- R7: Line-wise mode ignores x[4:0] and y[1:0] of the start coordinate. Column-wise mode ignores y[4:0] and x[1:0].
- R8: `done_o` rises in the cycle of the last valid address and stays high until the next `start_i`. A count of 0 raises `done_o` one cycle after `start_i`, with no address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Load a new traversal request |
| mode_i | input | 1 | 0 line-wise, 1 column-wise |
| x_i | input | LOG_W | Start sample position |
| y_i | input | LOG_H | Start line |
| len_i | input | LEN_W | Number of bursts to generate |
| gen_en_i | input | 1 | Request for the next burst address |
| valid_o | output | 1 | Address outputs hold a new burst address |
| bank_o | output | 3 | Bank address |
| row_o | output | LOG_W+LOG_H-13 | Row address |
| col_o | output | 10 | Column address of the first word of the burst |
| done_o | output | 1 | All requested bursts have been issued |

## Verification
Two events can fall in the same cycle. A new request can coincide with a burst request, and the final burst can coincide with a request that is already arriving. The bench raises `start_i` together with `gen_en_i`, both in the middle of a run and at its end. It then judges that the cycle after shows no valid address. It also judges that the following bursts start from the new coordinate and that `done_o` follows the new count rather than the old one.

// File: rtl/xpose_addr_gen.sv
module xpose_addr_gen #(
  parameter int LOG_W = 7,
  parameter int LOG_H = 7,
  parameter int LEN_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic                       mode_i,
  input  logic [LOG_W-1:0]           x_i,
  input  logic [LOG_H-1:0]           y_i,
  input  logic [LEN_W-1:0]           len_i,
  input  logic                       gen_en_i,
  output logic                       valid_o,
  output logic [2:0]                 bank_o,
  output logic [LOG_W+LOG_H-14:0]    row_o,
  output logic [9:0]                 col_o,
  output logic                       done_o
);
  localparam int TILE_L = 5;
  localparam int BX_W   = LOG_W - TILE_L;
  localparam int BY_W   = LOG_H - TILE_L;
  localparam int TI_W   = BX_W + BY_W;

  logic            mode_q;
  logic [3:0]      k_q, k_n;
  logic [2:0]      g_q, g_n;
  logic [BX_W-1:0] bx_q, bx_n;
  logic [BY_W-1:0] by_q, by_n;
  logic [LEN_W-1:0] rem_q;

  logic [TI_W-1:0] tile;
  logic [9:0]      col_c;
  logic            go;
  logic            unused_bits;

  assign tile  = {by_q, bx_q};
  assign col_c = mode_q ? {k_q, g_q, 3'b000} : {g_q, k_q, 3'b000};
  assign go    = gen_en_i && !start_i && (rem_q != '0);
  assign unused_bits = ^{x_i[1:0], y_i[1:0]};

  always_comb begin
    k_n  = k_q + 4'd1;
    g_n  = g_q;
    bx_n = bx_q;
    by_n = by_q;
    if (k_q == 4'd15) begin
      if (!mode_q) begin
        bx_n = bx_q + BX_W'(1);
        if (&bx_q) begin
          g_n = g_q + 3'd1;
          if (g_q == 3'd7) by_n = by_q + BY_W'(1);
        end
      end else begin
        by_n = by_q + BY_W'(1);
        if (&by_q) begin
          g_n = g_q + 3'd1;
          if (g_q == 3'd7) bx_n = bx_q + BX_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      k_q     <= '0;
      g_q     <= '0;
      bx_q    <= '0;
      by_q    <= '0;
      rem_q   <= '0;
      valid_o <= 1'b0;
      bank_o  <= '0;
      row_o   <= '0;
      col_o   <= '0;
      done_o  <= 1'b0;
    end else if (start_i) begin
      mode_q  <= mode_i;
      k_q     <= '0;
      g_q     <= mode_i ? x_i[4:2] : y_i[4:2];
      bx_q    <= x_i[LOG_W-1:TILE_L];
      by_q    <= y_i[LOG_H-1:TILE_L];
      rem_q   <= len_i;
      valid_o <= 1'b0;
      done_o  <= (len_i == '0);
    end else begin
      valid_o <= go;
      if (go) begin
        bank_o <= tile[2:0];
        row_o  <= tile[TI_W-1:3];
        col_o  <= col_c;
        k_q    <= k_n;
        g_q    <= g_n;
        bx_q   <= bx_n;
        by_q   <= by_n;
        rem_q  <= rem_q - LEN_W'(1);
        if (rem_q == LEN_W'(1)) done_o <= 1'b1;
      end
    end
  end

  AST_START_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !valid_o); // R2
  AST_VALID_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ($past(gen_en_i) && !$past(start_i))); // R3
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> !valid_o); // R3
  AST_LINE_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(valid_o) && !mode_q && $past(col_o[6:3]) != 4'd15)
      |-> (col_o == $past(col_o) + 10'd8 && bank_o == $past(bank_o) && row_o == $past(row_o))); // R5
  AST_COLUMN_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(valid_o) && mode_q && $past(col_o[9:6]) != 4'd15)
      |-> (col_o == $past(col_o) + 10'd64 && bank_o == $past(bank_o) && row_o == $past(row_o))); // R6
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o); // R8
endmodule

// File: tb/xpose_addr_gen_bench.sv
module xpose_addr_gen_bench;
  localparam int W = 128, H = 128, NBX = W / 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, mode_i = 1'b0, gen_en_i = 1'b0;
  logic [6:0] x_i = '0, y_i = '0;
  logic [15:0] len_i = '0;
  logic valid_o, done_o;
  logic [2:0] bank_o;
  logic [0:0] row_o;
  logic [9:0] col_o;

  int checks = 0, errors = 0;
  int qb[$], qr[$], qc[$];
  bit exp_valid = 0, exp_done = 0;
  int exp_b, exp_r, exp_c;
  bit finished = 0;

  always #10 clk = ~clk;

  xpose_addr_gen u_xpose_addr_gen (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .x_i(x_i), .y_i(y_i), .len_i(len_i), .gen_en_i(gen_en_i),
    .valid_o(valid_o), .bank_o(bank_o), .row_o(row_o), .col_o(col_o),
    .done_o(done_o));

  task automatic push_addr(int ex, int ey);
    int t;
    t = (ey / 32) * NBX + ex / 32;
    qb.push_back(t % 8);
    qr.push_back(t / 8);
    qc.push_back(((ey % 32) / 2) * 64 + (ex % 32) * 2 + (ey % 2));
  endtask

  task automatic build(bit md, int x0, int y0, int len);
    int n = 0;
    bit first = 1;
    qb.delete(); qr.delete(); qc.delete();
    if (!md) begin
      int g = y0 / 4;
      while (n < len) begin
        for (int bx = (first ? x0 / 32 : 0); bx < W / 32 && n < len; bx++)
          for (int k = 0; k < 16 && n < len; k++) begin
            push_addr(bx * 32 + (k % 8) * 4, 4 * g + 2 * (k / 8));
            n++;
          end
        first = 0;
        g = (g + 1) % (H / 4);
      end
    end else begin
      int q = x0 / 4;
      while (n < len) begin
        for (int by = (first ? y0 / 32 : 0); by < H / 32 && n < len; by++)
          for (int k = 0; k < 16 && n < len; k++) begin
            push_addr(4 * q, by * 32 + 2 * k);
            n++;
          end
        first = 0;
        q = (q + 1) % (W / 4);
      end
    end
  endtask

  task automatic step(bit st, bit md, int xx, int yy, int ln, bit ge, string tag);
    @(negedge clk);
    checks++;
    if (valid_o !== exp_valid) begin
      errors++;
      $display("FAIL %s valid got %0d exp %0d", tag, valid_o, exp_valid);
    end
    checks++;
    if (done_o !== exp_done) begin
      errors++;
      $display("FAIL %s done got %0d exp %0d", tag, done_o, exp_done);
    end
    if (exp_valid) begin
      checks++;
      if (bank_o != exp_b || row_o != exp_r || col_o != exp_c) begin
        errors++;
        $display("FAIL R4 %s addr got b%0d r%0d c%0d exp b%0d r%0d c%0d",
                 tag, bank_o, row_o, col_o, exp_b, exp_r, exp_c);
      end
    end
    start_i = st; mode_i = md; x_i = 7'(xx); y_i = 7'(yy);
    len_i = 16'(ln); gen_en_i = ge;
    if (st) begin
      build(md, xx, yy, ln);
      exp_valid = 0;
      exp_done = (ln == 0);
    end else if (ge && qb.size() > 0) begin
      exp_valid = 1;
      exp_b = qb.pop_front(); exp_r = qr.pop_front(); exp_c = qc.pop_front();
      if (qb.size() == 0) exp_done = 1;
    end else begin
      exp_valid = 0;
    end
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic gens(int n, bit alternate, string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, alternate ? (i % 2 == 0) : 1'b1, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2, "R1");
    gens(3, 0, "R3");
    step(1, 0, 0, 0, 80, 0, "R5");
    gens(82, 0, "R5");
    gens(3, 0, "R8");
    step(1, 0, 37, 6, 40, 0, "R7");
    gens(84, 1, "R7");
    step(1, 0, 96, 124, 24, 0, "R5");
    gens(26, 0, "R5");
    step(1, 1, 0, 0, 70, 0, "R6");
    gens(72, 0, "R6");
    step(1, 1, 125, 99, 24, 0, "R7");
    gens(26, 1, "R6");
    step(1, 1, 64, 32, 30, 1, "R2");
    gens(5, 0, "R2");
    step(1, 0, 32, 64, 10, 1, "R2");
    gens(12, 0, "R2");
    step(1, 1, 8, 0, 20, 1, "R2");
    gens(3, 0, "R3");
    step(1, 0, 0, 0, 0, 0, "R8");
    gens(4, 0, "R8");
    idle(2, "R8");
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule